// File: doc/BRIEF.md
# Enable-Steered Bus Capture Across Clock Domains

This block moves a multi-bit data word from a source clock domain into a destination clock domain. Only one bit, a source-side enable that announces a fresh word, passes through a flip-flop synchronizer. The data bits are never synchronized one by one. In the destination domain, a rising edge on the synchronized enable steers a hold/load multiplexer in front of the destination data register. For that one cycle the register takes the source bus. In every other cycle the multiplexer feeds the register's own output back to its input.

The source first registers the enable in its own clock domain, so the bit that crosses is free of glitches. The same registered copy feeds exactly one synchronizer chain. The source must hold the data bus steady from before it raises the enable until the destination has captured the word. This takes at least the synchronizer depth plus one destination cycles. A single-cycle update pulse marks the cycle in which the newly captured word appears.

Top module: `bus_capture_sync`

## Requirements
- R1: While the destination reset is held, and in the first destination cycle after it, the captured word reads zero and the update pulse is low.
- R2: Every update pulse is high for exactly one destination cycle.
- R3: In the cycle the update pulse is high, the captured word equals the word that the source held stable on its bus when it raised the enable. It is never a mix of bits from two words.
- R4: A change of the source bus while the enable is low changes neither the captured word nor the update pulse.
- R5: Holding the enable high for many cycles produces only one update. Another update needs the enable to fall and rise again.
- R6: With the default depth of 2 synchronizer stages, the update pulse rises between STAGES+1 and STAGES+3 destination cycles after the source raises the enable. The exact cycle depends on the phase of the two clocks.
- R7: Between update pulses, the captured word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain reset, active low |
| srcData | input | WIDTH | Source data bus; held stable while a transfer is in flight |
| srcValid | input | 1 | Source enable; a rising edge announces a new word |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination domain reset, active low |
| dstData | output | WIDTH | Captured word in the destination domain |
| dstUpdate | output | 1 | One-cycle pulse; high in the cycle a new word appears on dstData |

## Verification
Every one of the 256 possible 8-bit words is sent in turn. A capture that dropped, swapped or stuck a bit would therefore show as a wrong word for some value. After each capture the enable stays high for several more cycles, which separates edge-triggered loading from level-triggered loading. While the enable is low, the bus is then driven to the bitwise complement of the last word. This shows whether the register truly recirculates its own value or leaks the bus through. The two clocks run at unrelated periods, so the measured latency covers several phase offsets and is checked against the allowed window.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  // strobes sent from the control path to the destination datapath
  typedef struct packed {
    logic load;   // take the source bus this cycle
  } dstStrobes_t;
endpackage

// File: rtl/bcs_ctrl.sv
`timescale 1ns/1ps
module bcs_ctrl #(
  parameter int STAGES = 2
) (
  input  logic                   srcClk,
  input  logic                   srcRstN,
  input  logic                   srcEnable,
  input  logic                   dstClk,
  input  logic                   dstRstN,
  output bcs_pkg::dstStrobes_t   strobes
);
  localparam int LAST = STAGES - 1;

  // enable registered in its own domain: the only bit that crosses
  logic srcEnReg;
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) srcEnReg <= 1'b0;
    else          srcEnReg <= srcEnable;
  end

  // single synchronizer chain in the destination domain
  logic [STAGES-1:0] syncChain;
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge dstClk or negedge dstRstN) begin
          if (!dstRstN) syncChain[gi] <= 1'b0;
          else          syncChain[gi] <= srcEnReg;
        end
      end else begin : g_next
        always_ff @(posedge dstClk or negedge dstRstN) begin
          if (!dstRstN) syncChain[gi] <= 1'b0;
          else          syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  // rising-edge detect on the synchronized enable
  logic syncPrev;
  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) syncPrev <= 1'b0;
    else          syncPrev <= syncChain[LAST];
  end

  always_comb begin
    strobes.load = syncChain[LAST] & ~syncPrev;
  end

  // a level held high yields only one load strobe
  assert_one_load_R5: assert property (@(posedge dstClk) disable iff (!dstRstN)
    strobes.load |=> !strobes.load);
endmodule

// File: rtl/bcs_datapath.sv
`timescale 1ns/1ps
module bcs_datapath #(
  parameter int WIDTH = 8
) (
  input  logic                   dstClk,
  input  logic                   dstRstN,
  input  logic [WIDTH-1:0]       srcData,
  input  bcs_pkg::dstStrobes_t   strobes,
  output logic [WIDTH-1:0]       dstData,
  output logic                   dstUpdate
);
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] dataNext;
  logic             updReg;

  // recirculating mux: load the bus or feed the register back
  always_comb begin
    dataNext = strobes.load ? srcData : dataReg;
  end

  always_ff @(posedge dstClk or negedge dstRstN) begin
    if (!dstRstN) begin
      dataReg <= '0;
      updReg  <= 1'b0;
    end else begin
      dataReg <= dataNext;
      updReg  <= strobes.load;
    end
  end

  assign dstData   = dataReg;
  assign dstUpdate = updReg;

  assert_single_pulse_R2: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstUpdate |=> !dstUpdate);

  assert_capture_R3: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstUpdate |-> (dstData == $past(srcData)));

  assert_hold_R7: assert property (@(posedge dstClk) disable iff (!dstRstN)
    !dstUpdate |-> $stable(dstData));
endmodule

// File: rtl/bus_capture_sync.sv
`timescale 1ns/1ps
module bus_capture_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [WIDTH-1:0]  srcData,
  input  logic              srcValid,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [WIDTH-1:0]  dstData,
  output logic              dstUpdate
);
  bcs_pkg::dstStrobes_t strobes;

  bcs_ctrl #(.STAGES(STAGES)) i_ctrl (
    .srcClk    (srcClk),
    .srcRstN   (srcRstN),
    .srcEnable (srcValid),
    .dstClk    (dstClk),
    .dstRstN   (dstRstN),
    .strobes   (strobes)
  );

  bcs_datapath #(.WIDTH(WIDTH)) i_datapath (
    .dstClk    (dstClk),
    .dstRstN   (dstRstN),
    .srcData   (srcData),
    .strobes   (strobes),
    .dstData   (dstData),
    .dstUpdate (dstUpdate)
  );
endmodule

// File: tb/test_bus_capture_sync.sv
`timescale 1ns/1ps
module test_bus_capture_sync;
  localparam int WIDTH  = 8;
  localparam int STAGES = 2;

  logic srcClk = 1'b0;
  logic dstClk = 1'b0;
  logic srcRstN = 1'b0;
  logic dstRstN = 1'b0;
  logic [WIDTH-1:0] srcData = '0;
  logic srcValid = 1'b0;
  logic [WIDTH-1:0] dstData;
  logic dstUpdate;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #6.5 srcClk = ~srcClk;
  always #5   dstClk = ~dstClk;   // 100 MHz destination clock

  bus_capture_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) i_bus_capture_sync (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcData(srcData), .srcValid(srcValid),
    .dstClk(dstClk), .dstRstN(dstRstN), .dstData(dstData), .dstUpdate(dstUpdate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit found;
    bit sawUpd;
    repeat (3) @(negedge dstClk);
    check(dstData == 0 && dstUpdate == 0, "R1 in reset", int'(dstData), 0);
    srcRstN = 1'b1;
    dstRstN = 1'b1;
    @(negedge dstClk);
    check(dstData == 0 && dstUpdate == 0, "R1 after reset", int'(dstData), 0);

    for (int v = 0; v < (1 << WIDTH); v++) begin
      @(negedge srcClk) srcData = WIDTH'(v);
      @(negedge srcClk) srcValid = 1'b1;
      n = 0;
      found = 0;
      while (n < STAGES + 6 && !found) begin
        @(negedge dstClk);
        n++;
        if (dstUpdate) found = 1;
      end
      check(found && n >= STAGES + 1 && n <= STAGES + 3, "R6 latency", n, STAGES + 1);
      check(dstData == WIDTH'(v), "R3 captured word", int'(dstData), v);
      @(negedge dstClk);
      check(!dstUpdate, "R2 pulse width", int'(dstUpdate), 0);
      for (int k = 0; k < 3; k++) begin
        @(negedge dstClk);
        check(!dstUpdate && dstData == WIDTH'(v), "R5 held enable", int'(dstUpdate), 0);
      end
      @(negedge srcClk) srcValid = 1'b0;
      repeat (STAGES + 3) @(negedge dstClk);
      @(negedge srcClk) srcData = ~WIDTH'(v);
      sawUpd = 0;
      repeat (STAGES + 4) begin
        @(negedge dstClk);
        sawUpd |= dstUpdate;
      end
      check(!sawUpd && dstData == WIDTH'(v), "R4 R7 bus change ignored", int'(dstData), v);
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule